// File: doc/BRIEF.md
# Output Compare Channel with Forced Levels

This block is one output-compare channel. It watches a counter value that comes from outside the block and compares it with a compare value. Software loads that compare value into a preload register. An update strobe then copies it into a shadow register, and only the shadow takes part in the comparison. A 3-bit mode field decides what the active-high reference output does: hold its level, set on a match, clear on a match, toggle on a match, or be forced low or high.

The pin output is the reference passed through a polarity bit. The comparison never stops, even in the forced modes. Each new match sets a sticky flag, and the flag drives a level interrupt request whenever the interrupt enable is high. A one-cycle clear input drops the flag.

Top module: `occ_channel`

## Requirements
- R1: After a synchronous active-low reset, ref_o, flag_o and irq_o are 0, pin_o equals pol_i, and both the preload and shadow compare values are 0.
- R2: cmp_wr_i loads cmp_val_i into the preload register. The shadow compare value changes only on a clock with cmp_upd_i high. On that clock it takes the preload value, or cmp_val_i when cmp_wr_i is high in the same clock.
- R3: A match is raised only on the first clock in which cnt_i equals the shadow value. A counter that stays equal does not raise a second match.
- R4: On a match clock, the reference becomes 1 in mode 3'b001, becomes 0 in mode 3'b010, and inverts in mode 3'b011. The new level shows at the next clock edge. Without a match these modes keep the reference unchanged.
- R5: Mode 3'b000 holds the reference at its current level, whether or not a match occurs.
- R6: Mode 3'b101 drives the reference to 1 and mode 3'b100 drives it to 0 at the next clock edge. The compare result has no effect on this.
- R7: A match in a forced mode still sets flag_o.
- R8: pin_o equals ref_o when pol_i is 0 and equals the inverse of ref_o when pol_i is 1. The polarity path is combinational.
- R9: flag_o sets one clock after a match and stays set until a clock with flag_clr_i high. If a match and a clear fall in the same clock, the flag stays set.
- R10: irq_o is high exactly when flag_o is high and irq_en_i is high.
- R11: The unused modes 3'b110 and 3'b111 hold the reference like mode 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | CNT_W | Counter value from the external time base |
| cmp_wr_i | input | 1 | Write strobe for the preload compare register |
| cmp_val_i | input | CNT_W | Compare value to load into the preload register |
| cmp_upd_i | input | 1 | Update event that copies the preload value into the shadow register |
| mode_i | input | 3 | Reference output mode |
| pol_i | input | 1 | Output polarity; 1 inverts the pin |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle clear for the match flag |
| ref_o | output | 1 | Active-high reference output |
| pin_o | output | 1 | Output pin after polarity |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A shadow register that holds the wrong value shows at the ports as a flag that never sets, or sets on the wrong counter value, one clock after that value is presented. A broken edge detector shows as the flag coming back on the clock after a clear while the counter is held, or as a toggle mode that flips the reference twice. An error in the mode decode shows on ref_o and pin_o at the first clock edge after the mode is applied. The forced and hold modes are run with matches present, so a reference that follows the compare result in those modes is caught at once.

// File: rtl/occ_pkg.sv
// Package: shared types and the reference next-state function for the
// output-compare channel. Assumes a 3-bit mode field.
package occ_pkg;

    typedef enum logic [2:0] {
        OC_HOLD     = 3'b000,
        OC_SET      = 3'b001,
        OC_CLEAR    = 3'b010,
        OC_TOGGLE   = 3'b011,
        OC_FORCE_LO = 3'b100,
        OC_FORCE_HI = 3'b101,
        OC_RSV_6    = 3'b110,
        OC_RSV_7    = 3'b111
    } occ_mode_e;

    // Next reference level from mode, match pulse and current level.
    function automatic logic occ_next_ref(input occ_mode_e mode,
                                          input logic      hit,
                                          input logic      cur);
        logic nxt;
        nxt = cur;
        unique case (mode)
            OC_SET:      if (hit) nxt = 1'b1;
            OC_CLEAR:    if (hit) nxt = 1'b0;
            OC_TOGGLE:   if (hit) nxt = ~cur;
            OC_FORCE_LO: nxt = 1'b0;
            OC_FORCE_HI: nxt = 1'b1;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/occ_cmp_shadow.sv
// Module: compare value preload and shadow registers.
// Assumes that the update strobe is a single-cycle event from the time base.
// A write in the same clock as an update goes straight into the shadow.
module occ_cmp_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             upd_i,
    output logic [CNT_W-1:0] shadow_o
);

    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] preload_nxt;

    // Value the preload register will hold after this clock.
    always_comb preload_nxt = wr_i ? val_i : preload_q;

    // Preload register: captures software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) preload_q <= '0;
        else        preload_q <= preload_nxt;
    end

    // Shadow register: follows the preload only on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (upd_i) shadow_q <= preload_nxt;
    end

    assign shadow_o = shadow_q;

    // R2: the shadow value stays put without an update event.
    assert_shadow_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(shadow_q));

endmodule

// File: rtl/occ_match_det.sv
// Module: compare match detector.
// Raises match_o only on the first clock in which the counter equals the shadow
// value, so a counter that sits on the compare value matches once.
// Assumes that cnt_i is stable around the clock edge.
module occ_match_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             match_o
);

    logic eq;
    logic eq_q;

    // Raw equality between the counter and the shadow value.
    always_comb eq = (cnt_i == cmp_i);

    // Remembers whether equality held in the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // A match is the rising edge of equality.
    always_comb match_o = eq && !eq_q;

    // R3: two matches never come in back-to-back clocks.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

endmodule

// File: rtl/occ_ref_gen.sv
// Module: reference waveform generator.
// Updates the active-high reference level from the mode and the match pulse.
// The forced modes override the compare result. Assumes a 3-bit mode field.
module occ_ref_gen
    import occ_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       match_i,
    output logic       ref_o
);

    occ_mode_e mode;
    logic      ref_q;

    // Decodes the raw mode bits into the enumerated mode.
    always_comb mode = occ_mode_e'(mode_i);

    // Reference register: next level from the package function.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= occ_next_ref(mode, match_i, ref_q);
    end

    assign ref_o = ref_q;

    // R6: forced high wins over any compare result.
    assert_force_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b101) |=> ref_q);
    // R6: forced low wins over any compare result.
    assert_force_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b100) |=> !ref_q);
    // R5, R11: the hold and unused modes keep the level.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000 || mode_i[2:1] == 2'b11) |=> $stable(ref_q));
    // R4: the toggle mode inverts the level on a match.
    assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b011 && match_i) |=> (ref_q != $past(ref_q)));

endmodule

// File: rtl/occ_flag.sv
// Module: sticky match flag and interrupt request.
// The flag sets on a match and clears on a clear strobe; a match wins over a
// clear in the same clock. Assumes that the clear is a single-cycle strobe.
module occ_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    // Flag register: a set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (match_i) flag_q <= 1'b1;
        else if (clr_i)   flag_q <= 1'b0;
    end

    // Level interrupt request while the flag is set and enabled.
    always_comb irq_o = flag_q && irq_en_i;

    assign flag_o = flag_q;

    // R7, R9: every match leaves the flag set.
    assert_match_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> flag_q);
    // R9: a clear without a match drops the flag.
    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !match_i) |=> !flag_q);

endmodule

// File: rtl/occ_channel.sv
// Module: top of the output-compare channel.
// Connects the shadow compare register, the match detector, the reference
// generator and the flag, then applies output polarity to the reference.
// Assumes that the counter comes from an external time base in the same clock domain.
module occ_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cmp_upd_i,
    input  logic [2:0]       mode_i,
    input  logic             pol_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic             ref_o,
    output logic             pin_o,
    output logic             flag_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] shadow;
    logic             match;
    logic             ref_lvl;

    occ_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cmp_wr_i),
        .val_i    (cmp_val_i),
        .upd_i    (cmp_upd_i),
        .shadow_o (shadow)
    );

    occ_match_det #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .cmp_i   (shadow),
        .match_o (match)
    );

    occ_ref_gen u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .match_i (match),
        .ref_o   (ref_lvl)
    );

    occ_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .flag_o   (flag_o),
        .irq_o    (irq_o)
    );

    // Polarity stage: the pin is the reference, inverted when pol_i is high.
    always_comb pin_o = pol_i ? ~ref_lvl : ref_lvl;

    assign ref_o = ref_lvl;

    // R7: a forced mode does not stop the flag from setting on a match.
    assert_forced_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_i[2:1] == 2'b10) |=> flag_o);

endmodule

// File: tb/occ_channel_bench.sv
// Bench: a vector table walked once, then directed tests for preload,
// polarity and reset.
module occ_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NV = 22;

    // Vector layout: [31:16] cnt, [15:13] mode, [12] pol, [11] clr, [10] en,
    // [9] exp ref, [8] exp pin, [7] exp flag, [6] exp irq.
    localparam logic [31:0] VEC [NV] = '{
        {16'd3, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd5, 3'b010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd7, 3'b101, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0},
        {16'd6, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0},
        {16'd5, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
        {16'd5, 3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0},
        {16'd6, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '1;
    logic         cmp_wr_i = 1'b0;
    logic [W-1:0] cmp_val_i = '0;
    logic         cmp_upd_i = 1'b0;
    logic [2:0]   mode_i = 3'b000;
    logic         pol_i = 1'b0;
    logic         irq_en_i = 1'b1;
    logic         flag_clr_i = 1'b0;
    logic         ref_o, pin_o, flag_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;

    occ_channel #(.CNT_W(W)) u_occ_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_wr_i(cmp_wr_i),
        .cmp_val_i(cmp_val_i), .cmp_upd_i(cmp_upd_i), .mode_i(mode_i),
        .pol_i(pol_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
        .ref_o(ref_o), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    // One clock: inputs are already driven at a negedge, the check is at the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ref", ref_o, 1'b0);
        chk("R1 pin", pin_o, 1'b0);
        chk("R1 flag", flag_o, 1'b0);
        chk("R1 irq", irq_o, 1'b0);
        rst_n = 1'b1;
        tick();
        // R1: the shadow starts at 0, so a counter of 0 matches
        cnt_i = 16'd0;
        tick();
        chk("R1 shadow zero match", flag_o, 1'b1);
        // R2: a write and an update in the same clock load the new value
        cnt_i = 16'd9; flag_clr_i = 1'b1;
        cmp_wr_i = 1'b1; cmp_val_i = 16'd5; cmp_upd_i = 1'b1;
        tick();
        cmp_wr_i = 1'b0; cmp_upd_i = 1'b0; flag_clr_i = 1'b0;
        chk("R2 flag cleared", flag_o, 1'b0);

        // Table walk, shadow = 5
        for (int i = 0; i < NV; i++) begin
            cnt_i      = VEC[i][31:16];
            mode_i     = VEC[i][15:13];
            pol_i      = VEC[i][12];
            flag_clr_i = VEC[i][11];
            irq_en_i   = VEC[i][10];
            tick();
            chk($sformatf("R4/R5/R6/R11 ref v%0d", i), ref_o, VEC[i][9]);
            chk($sformatf("R8 pin v%0d", i), pin_o, VEC[i][8]);
            chk($sformatf("R3/R7/R9 flag v%0d", i), flag_o, VEC[i][7]);
            chk($sformatf("R10 irq v%0d", i), irq_o, VEC[i][6]);
        end
        flag_clr_i = 1'b0;

        // R8: the polarity path is combinational
        pol_i = 1'b0;
        #1 chk("R8 pol0 comb", pin_o, ref_o);
        pol_i = 1'b1;
        #1 chk("R8 pol1 comb", pin_o, ~ref_o);
        @(negedge clk);

        // R2: a preload write without an update leaves the compare value unchanged
        mode_i = 3'b000; cnt_i = 16'd8;
        cmp_wr_i = 1'b1; cmp_val_i = 16'd9;
        tick();
        cmp_wr_i = 1'b0;
        cnt_i = 16'd9;
        tick();
        chk("R2 preload no effect", flag_o, 1'b0);
        cnt_i = 16'd8; cmp_upd_i = 1'b1;
        tick();
        cmp_upd_i = 1'b0; cnt_i = 16'd9;
        tick();
        chk("R2 update applied", flag_o, 1'b1);

        // R3: a held counter does not match again after a clear
        flag_clr_i = 1'b1;
        tick();
        flag_clr_i = 1'b0;
        tick();
        chk("R3 no rematch while held", flag_o, 1'b0);

        // R1: a reset during operation
        mode_i = 3'b101;
        tick();
        chk("R6 force hi pre-reset", ref_o, 1'b1);
        rst_n = 1'b0; pol_i = 1'b0;
        tick();
        chk("R1 ref after reset", ref_o, 1'b0);
        chk("R1 flag after reset", flag_o, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule